// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It runs on the test clock, follows the mode-select input through a sixteen-state sequencer, and can be forced back to its reset state at any moment by an active-low asynchronous reset. A four-bit instruction register selects which data register sits between the serial input and the serial output. Two data registers are provided. One is a single-stage bypass register. The other is a 32-bit identification register, which a parameter can remove.

The sequencer decodes its state into three strobes that tell the selected data register when to capture, when to shift and when to update. The loaded instruction is the block's parallel output. It changes only on the falling clock edge in the update state of the instruction path. The serial output also changes on the falling edge, and it is driven only while a shift state is active.

Top module: `tap_ctrl`

## Requirements
- R1: The `tap_state` output uses the following encoding: 0 reset, 1 idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR. The state changes on each rising `tck` edge according to `tms`, following the standard sixteen-state transition graph. In that graph the IR branch mirrors the DR branch, and select-IR with `tms`=1 returns to reset.
- R2: While `trst_n` is low, the state is reset (0) at once, without any clock edge, `tdo_oe` is 0 and `tdo` is high impedance. After release, stepping resumes normally.
- R3: Whenever the state is reset, the instruction becomes the identification code 4'b0010. When the identification register is not built, it becomes the bypass code 4'b1111, and the first bit shifted out of the data path is 0.
- R4: Five consecutive rising edges with `tms`=1 reach the reset state from any state.
- R5: In capture-IR the instruction shift register loads 4'b0001. In shift-IR it shifts toward `tdo`, least significant bit first, and `tdi` enters at the most significant bit.
- R6: A new instruction appears on `instr` only at the falling `tck` edge during update-IR, not at the rising edge that enters that state.
- R7: When `instr` is 4'b0010, capture-DR loads 32'h4A3B6C1F (least significant bit 1), which shift-DR then moves out least significant bit first.
- R8: For any instruction other than the identification code, the bypass stage is selected. It captures 0 and delays `tdi` by one shift.
- R9: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 only in shift-DR and shift-IR. Otherwise `tdo` is high impedance.
- R10: `capture_dr`, `shift_dr` and `update_dr` are each high exactly in their own state, and at most one of them is high at a time.
- R11: In exit1-DR, pause-DR and exit2-DR the data register holds its contents, so a scan that pauses partway continues with the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, high impedance when not shifting |
| tdo_oe | output | 1 | Output enable for `tdo` |
| tap_state | output | 4 | Current sequencer state (encoding in R1) |
| instr | output | IR_W | Active instruction (parallel update output) |
| capture_dr | output | 1 | Selected data register captures |
| shift_dr | output | 1 | Selected data register shifts |
| update_dr | output | 1 | Selected data register updates |

## Verification
Several situations are hard to reach from the pins. One is a data scan that leaves shift-DR halfway through the identification word, waits in pause-DR and then resumes. Another is the half-cycle gap between entering update-IR and the new instruction appearing. The stimulus reaches the first by driving the exact mode-select sequence exit1, pause, pause, exit2, shift after bit 15, then checking that bit 16 follows and that the output is released while paused. It reaches the second by sampling `instr` just after the rising edge and again just after the falling edge. A second instance built without the identification register shares the same stimulus, which exercises the bypass fallback.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_DR_SEL   = 4'd2,
        ST_DR_CAP   = 4'd3,
        ST_DR_SHIFT = 4'd4,
        ST_DR_EXIT1 = 4'd5,
        ST_DR_PAUSE = 4'd6,
        ST_DR_EXIT2 = 4'd7,
        ST_DR_UPD   = 4'd8,
        ST_IR_SEL   = 4'd9,
        ST_IR_CAP   = 4'd10,
        ST_IR_SHIFT = 4'd11,
        ST_IR_EXIT1 = 4'd12,
        ST_IR_PAUSE = 4'd13,
        ST_IR_EXIT2 = 4'd14,
        ST_IR_UPD   = 4'd15
    } tap_state_e;

    // next state from current state and mode select
    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            ST_RESET:    return m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     return m ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   return m ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   return m ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: return m ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: return m ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: return m ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: return m ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   return m ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   return m ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   return m ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: return m ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: return m ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: return m ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: return m ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   return m ? ST_DR_SEL   : ST_IDLE;
            default:     return ST_RESET;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.st = tap_next(fsm_q.st, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) fsm_q <= '{st: ST_RESET};
        else         fsm_q <= fsm_d;
    end

    assign state_o = fsm_q.st;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
#(
    parameter int              IR_W       = 4,
    parameter logic [IR_W-1:0] RESET_CODE = '1
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic            sr_lsb,
    output logic [IR_W-1:0] instr
);

    localparam logic [IR_W-1:0] CAP_PAT = IR_W'(2'b01);

    typedef struct packed {
        logic [IR_W-1:0] sr;
    } shf_t;

    typedef struct packed {
        logic [IR_W-1:0] code;
    } upd_t;

    shf_t shf_d, shf_q;
    upd_t upd_d, upd_q;

    // shift stage, rising edge
    always_comb begin
        shf_d = shf_q;
        case (state)
            ST_IR_CAP:   shf_d.sr = CAP_PAT;
            ST_IR_SHIFT: shf_d.sr = {tdi, shf_q.sr[IR_W-1:1]};
            default:     ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) shf_q <= '{sr: CAP_PAT};
        else         shf_q <= shf_d;
    end

    // parallel stage, falling edge
    always_comb begin
        upd_d = upd_q;
        if (state == ST_IR_UPD)     upd_d.code = shf_q.sr;
        else if (state == ST_RESET) upd_d.code = RESET_CODE;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) upd_q <= '{code: RESET_CODE};
        else         upd_q <= upd_d;
    end

    assign sr_lsb = shf_q.sr[0];
    assign instr  = upd_q.code;

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter bit          HAS_ID = 1'b1,
    parameter logic [31:0] ID_VAL = 32'h0000_0001
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state,
    input  logic       sel_id,
    output logic       dr_lsb
);

    localparam int ID_W = $bits(ID_VAL);

    logic use_id;
    logic id_lsb;

    assign use_id = HAS_ID && sel_id;

    typedef struct packed {
        logic bp;
    } byp_t;

    byp_t byp_d, byp_q;

    always_comb begin
        byp_d = byp_q;
        if (!use_id) begin
            if (state == ST_DR_CAP)        byp_d.bp = 1'b0;
            else if (state == ST_DR_SHIFT) byp_d.bp = tdi;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) byp_q <= '{bp: 1'b0};
        else         byp_q <= byp_d;
    end

    generate
        if (HAS_ID) begin : g_id
            typedef struct packed {
                logic [ID_W-1:0] sr;
            } id_t;

            id_t id_d, id_q;

            always_comb begin
                id_d = id_q;
                if (use_id) begin
                    if (state == ST_DR_CAP)        id_d.sr = ID_VAL;
                    else if (state == ST_DR_SHIFT) id_d.sr = {tdi, id_q.sr[ID_W-1:1]};
                end
            end

            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) id_q <= '{sr: ID_VAL};
                else         id_q <= id_d;
            end

            assign id_lsb = id_q.sr[0];
        end else begin : g_no_id
            assign id_lsb = 1'b0;
        end
    endgenerate

    assign dr_lsb = use_id ? id_lsb : byp_q.bp;

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import tap_pkg::*;
#(
    parameter int              IR_W         = 4,
    parameter bit              HAS_IDCODE   = 1'b1,
    parameter logic [31:0]     IDCODE_VALUE = 32'h4A3B_6C1F,
    parameter logic [IR_W-1:0] IDCODE_INSTR = IR_W'(4'b0010)
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    output logic [3:0]      tap_state,
    output logic [IR_W-1:0] instr,
    output logic            capture_dr,
    output logic            shift_dr,
    output logic            update_dr
);

    localparam logic [IR_W-1:0] BYPASS_INSTR = '1;
    localparam logic [IR_W-1:0] RESET_CODE   = HAS_IDCODE ? IDCODE_INSTR : BYPASS_INSTR;

    tap_state_e st;
    logic       ir_lsb;
    logic       dr_lsb;

    tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (st)
    );

    tap_ir #(
        .IR_W       (IR_W),
        .RESET_CODE (RESET_CODE)
    ) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (st),
        .sr_lsb (ir_lsb),
        .instr  (instr)
    );

    tap_dr #(
        .HAS_ID (HAS_IDCODE),
        .ID_VAL (IDCODE_VALUE)
    ) u_dr (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (st),
        .sel_id (instr == IDCODE_INSTR),
        .dr_lsb (dr_lsb)
    );

    // serial output stage, falling edge
    typedef struct packed {
        logic oe;
        logic bit_o;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.oe    = (st == ST_DR_SHIFT) || (st == ST_IR_SHIFT);
        out_d.bit_o = (st == ST_IR_SHIFT) ? ir_lsb : dr_lsb;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) out_q <= '{oe: 1'b0, bit_o: 1'b0};
        else         out_q <= out_d;
    end

    assign tdo        = out_q.oe ? out_q.bit_o : 1'bz;
    assign tdo_oe     = out_q.oe;
    assign tap_state  = st;
    assign capture_dr = (st == ST_DR_CAP);
    assign shift_dr   = (st == ST_DR_SHIFT);
    assign update_dr  = (st == ST_DR_UPD);

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
    import tap_pkg::*;
#(
    parameter int              IR_W       = 4,
    parameter logic [IR_W-1:0] RESET_CODE = '1
) (
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input logic [3:0]      state,
    input logic [IR_W-1:0] instr,
    input logic            tdo_oe,
    input logic            capture_dr,
    input logic            shift_dr,
    input logic            update_dr
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)    ones_q <= '0;
        else if (!tms)  ones_q <= '0;
        else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
    end

    assert_reset_async_R2: assert property (@(posedge tck)
        !trst_n |-> state == ST_RESET);

    assert_exit1_update_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_DR_EXIT1 && tms) |=> state == ST_DR_UPD);

    assert_irsel_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IR_SEL && tms) |=> state == ST_RESET);

    assert_reset_instr_R3: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_RESET |-> instr == RESET_CODE);

    assert_five_ones_R4: assert property (@(posedge tck) disable iff (!trst_n)
        ones_q == 3'd5 |-> state == ST_RESET);

    assert_instr_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_IR_UPD && state != ST_RESET) |-> $stable(instr));

    assert_oe_shift_R9: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == (state == ST_DR_SHIFT || state == ST_IR_SHIFT));

    assert_strobe_excl_R10: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({capture_dr, shift_dr, update_dr}));

endmodule

bind tap_ctrl tap_ctrl_chk #(
    .IR_W       (IR_W),
    .RESET_CODE (RESET_CODE)
) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .tms        (tms),
    .state      (tap_state),
    .instr      (instr),
    .tdo_oe     (tdo_oe),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr)
);

// File: tb/sim_tap_ctrl.sv
`timescale 1ns/1ps
module sim_tap_ctrl;

    localparam logic [31:0] ID      = 32'h4A3B_6C1F;
    localparam logic [3:0]  ID_CODE = 4'b0010;
    localparam logic [3:0]  BY_CODE = 4'b1111;
    localparam int          NV      = 44;

    // {tms, expected state after the rising edge}
    localparam logic [4:0] VEC [0:NV-1] = '{
        {1'b1,4'd0},  {1'b0,4'd1},  {1'b0,4'd1},  {1'b1,4'd2},  {1'b0,4'd3},
        {1'b0,4'd4},  {1'b0,4'd4},  {1'b1,4'd5},  {1'b0,4'd6},  {1'b0,4'd6},
        {1'b1,4'd7},  {1'b0,4'd4},  {1'b1,4'd5},  {1'b1,4'd8},  {1'b1,4'd2},
        {1'b1,4'd9},  {1'b0,4'd10}, {1'b1,4'd12}, {1'b0,4'd13}, {1'b1,4'd14},
        {1'b0,4'd11}, {1'b1,4'd12}, {1'b1,4'd15}, {1'b1,4'd2},  {1'b0,4'd3},
        {1'b1,4'd5},  {1'b0,4'd6},  {1'b1,4'd7},  {1'b1,4'd8},  {1'b0,4'd1},
        {1'b1,4'd2},  {1'b1,4'd9},  {1'b0,4'd10}, {1'b0,4'd11}, {1'b0,4'd11},
        {1'b1,4'd12}, {1'b0,4'd13}, {1'b0,4'd13}, {1'b1,4'd14}, {1'b1,4'd15},
        {1'b0,4'd1},  {1'b1,4'd2},  {1'b1,4'd9},  {1'b1,4'd0}
    };

    logic       tck = 1'b0;
    logic       trst_n, tms, tdi;
    logic       tdo, tdo_oe, cap, shf, upd;
    logic [3:0] st, ins;
    logic       tdo1, oe1, cap1, shf1, upd1;
    logic [3:0] st1, ins1;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 tck = ~tck;

    tap_ctrl u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .tap_state(st), .instr(ins),
        .capture_dr(cap), .shift_dr(shf), .update_dr(upd)
    );

    tap_ctrl #(.HAS_IDCODE(1'b0)) u1 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo1), .tdo_oe(oe1), .tap_state(st1), .instr(ins1),
        .capture_dr(cap1), .shift_dr(shf1), .update_dr(upd1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        #1;
    endtask

    task automatic at_fall();
        @(negedge tck);
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        trst_n = 1'b0;
        tms    = 1'b1;
        tdi    = 1'b0;
        repeat (2) @(posedge tck);
        #1;
        // reset state
        chk("R2 state", st, 4'd0);
        chk("R2 oe", tdo_oe, 1'b0);
        chk("R2 tdo z", (tdo === 1'bz), 1'b1);
        chk("R3 instr", ins, ID_CODE);
        chk("R3 no-id instr", ins1, BY_CODE);
        at_fall();
        trst_n = 1'b1;

        // R1 / R10: transition table walk
        for (int k = 0; k < NV; k++) begin
            step(VEC[k][4], 1'b0);
            chk($sformatf("R1 vec %0d", k), st, VEC[k][3:0]);
            chk($sformatf("R10 vec %0d", k), {cap, shf, upd},
                {VEC[k][3:0] == 4'd3, VEC[k][3:0] == 4'd4, VEC[k][3:0] == 4'd8});
        end

        // R7 / R11 / R9: identification scan with a pause after bit 15
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 32; i++) begin
            at_fall();
            chk($sformatf("R7 id bit %0d", i), tdo, ID[i]);
            if (i == 0) begin
                chk("R9 oe in shift", tdo_oe, 1'b1);
                chk("R3 no-id bypass first bit", tdo1, 1'b0);
            end
            step((i == 15) || (i == 31), 1'b0);
            if (i == 15) begin
                step(1'b0, 1'b0);
                at_fall();
                chk("R9 oe in pause", tdo_oe, 1'b0);
                chk("R9 tdo z in pause", (tdo === 1'bz), 1'b1);
                step(1'b0, 1'b0);
                step(1'b1, 1'b0);
                step(1'b0, 1'b0);
                chk("R11 back in shift", st, 4'd4);
            end
        end
        step(1'b0, 1'b0);

        // R5 / R6: load the bypass instruction
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 shift-IR", st, 4'd11);
        for (int j = 0; j < 4; j++) begin
            at_fall();
            chk($sformatf("R5 capture bit %0d", j), tdo, (j == 0));
            step(j == 3, 1'b1);
        end
        step(1'b1, 1'b0);
        chk("R6 update-IR state", st, 4'd15);
        chk("R6 instr before fall", ins, ID_CODE);
        at_fall();
        chk("R6 instr after fall", ins, BY_CODE);
        step(1'b0, 1'b0);

        // R8: bypass data path
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        at_fall();
        chk("R8 bypass capture", tdo, 1'b0);
        for (int p = 0; p < 4; p++) begin
            step(1'b0, 1'(4'b1101 >> p));
            at_fall();
            chk($sformatf("R8 bypass delay %0d", p), tdo, 1'(4'b1101 >> p));
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 pause-DR", st, 4'd6);

        // R4: five ones from pause-DR
        for (int q = 0; q < 5; q++) step(1'b1, 1'b0);
        chk("R4 reached reset", st, 4'd0);
        at_fall();
        chk("R4 R3 instr restored", ins, ID_CODE);

        // R2: asynchronous reset mid-scan
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        at_fall();
        chk("R2 oe before reset", tdo_oe, 1'b1);
        trst_n = 1'b0;
        #1;
        chk("R2 async state", st, 4'd0);
        chk("R2 async oe", tdo_oe, 1'b0);
        chk("R2 async tdo z", (tdo === 1'bz), 1'b1);
        #1;
        trst_n = 1'b1;
        step(1'b0, 1'b0);
        chk("R2 resume", st, 4'd1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule